// File: doc/BRIEF.md
# Asynchronous Interrupt Priority Controller

This block sits beside a processor core and keeps track of the asynchronous interrupt sources that are waiting for service: a level-held external interrupt line, a one-cycle timer-expiry pulse from the decrementer, and a floating-point enabled-exception condition. It combines these with the live machine-state bits and picks at most one source to present to the core. The choice goes out as a request with a source code, a vector offset and the bits the entry logic must set in the saved-state register.

The request is recomputed in every cycle from the registered pending flags and the live state inputs. It therefore stays up until the core acknowledges it, and it changes at once when software rewrites the state or floating-point status bits. The external flag mirrors the line and survives delivery. The decrementer flag is consumed when the core takes it. Building the new machine state and the fetch address is left to the exception entry logic, and that logic clears the enable bit, so the core sees no second delivery until software sets the bit again.

Top module: `irq_prio_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after reset when all inputs are low, `reqValid` is 0, `reqCode` is 0 and `reqVector` is 0.
- R2: When `fpSummary` is 1 and at least one bit of `fpMode` is 1, the request is the floating-point source: `reqCode`=1, `reqVector`=0x700 and `reqSave`=2'b11 (bit 0 marks a floating-point enabled exception, bit 1 marks that the saved address is the next instruction). This holds whatever the value of `extEnable` and ranks above every other source.
- R3: The external and decrementer sources never raise a request while `extEnable` is 0. With no floating-point condition and `extEnable` at 0, `reqValid` is 0.
- R4: With `extEnable` at 1, no floating-point condition and the external source pending, the request is `reqCode`=2, `reqVector`=0x500, `reqSave`=0, even if the decrementer source is also pending.
- R5: The external pending flag takes the value of `extLine` at each clock edge. An acknowledge does not clear it, so the external request stays up for as long as the line stays high.
- R6: With `extEnable` at 1 and only the decrementer source pending, the request is `reqCode`=3, `reqVector`=0x900, `reqSave`=0. An acknowledge in that cycle clears the decrementer flag, unless `decPulse` is high in the same cycle.
- R7: A `decPulse` that arrives while `extEnable` is 0 is remembered, and the decrementer request appears in the first cycle in which `extEnable` is 1.
- R8: A change of `extEnable`, `fpMode` or `fpSummary` changes the request outputs in the same cycle. `ack` has no effect unless the selected source is the decrementer, so an acknowledge given while `extEnable` is 0 or while another source is selected leaves the decrementer flag pending.
- R9: When no request is raised, `reqCode`, `reqVector` and `reqSave` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extLine | input | 1 | Level-sensitive external interrupt line |
| decPulse | input | 1 | One-cycle decrementer expiry event |
| extEnable | input | 1 | External-interrupt enable bit of the machine state |
| fpMode | input | 2 | Floating-point exception mode bits of the machine state |
| fpSummary | input | 1 | Enabled-exception summary bit of the FP status register |
| ack | input | 1 | Core takes the presented request in this cycle |
| reqValid | output | 1 | A request is being presented |
| reqCode | output | 2 | Source: 0 none, 1 floating point, 2 external, 3 decrementer |
| reqVector | output | 12 | Vector offset of the selected source |
| reqSave | output | 2 | Saved-state bits to set: bit 0 FP enabled, bit 1 next instruction |

## Verification
Edges on `extLine` and `decPulse` reach the request one clock edge later, because they pass through the pending registers. Changes on the state inputs, and the removal of the decrementer flag after an acknowledge, show up with no delay or after that same single edge. The bench therefore drives all inputs just after a falling edge and compares every output a moment later, before the next rising edge. It tracks the two pending flags in a model that it updates at each rising edge, from the inputs it drove and from the expected selection. Random phases with mixed input densities run alongside directed sequences for the priority, hold and consume corner cases.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FP   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_DEC  = 2'd3
  } srcCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeDec;
  } ctlStrobe_t;

  localparam int SAVE_W = 2;
  localparam int SAVE_FP_BIT = 0;
  localparam int SAVE_NEXT_BIT = 1;

endpackage

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_FP  = 12'h700,
  parameter logic [VEC_W-1:0] VEC_EXT = 12'h500,
  parameter logic [VEC_W-1:0] VEC_DEC = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extLine,
  input  logic              decPulse,
  input  ctlStrobe_t        strobe,
  input  srcCode_e          selCode,
  output logic              extPend,
  output logic              decPend,
  output logic [VEC_W-1:0]  vecOut,
  output logic [SAVE_W-1:0] saveOut
);

  logic decNext;

  always_comb begin
    decNext = decPend;
    if (strobe.takeDec) decNext = 1'b0;
    if (decPulse)       decNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      extPend <= 1'b0;
      decPend <= 1'b0;
    end else begin
      extPend <= extLine;
      decPend <= decNext;
    end
  end

  always_comb begin
    vecOut  = '0;
    saveOut = '0;
    unique case (selCode)
      SRC_FP: begin
        vecOut = VEC_FP;
        saveOut[SAVE_FP_BIT]   = 1'b1;
        saveOut[SAVE_NEXT_BIT] = 1'b1;
      end
      SRC_EXT: vecOut = VEC_EXT;
      SRC_DEC: vecOut = VEC_DEC;
      default: ;
    endcase
  end

  AST_EXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    extLine |=> extPend) else $error("ext flag missed line"); // R5
  AST_EXT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !extLine |=> !extPend) else $error("ext flag stuck"); // R5
  AST_DEC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    decPulse |=> decPend) else $error("dec event lost"); // R7
  AST_DEC_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeDec && !decPulse) |=> !decPend) else $error("dec not consumed"); // R6
  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.takeDec |-> decPend) else $error("take without pending"); // R6

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       extPend,
  input  logic       decPend,
  input  logic       extEnable,
  input  logic [1:0] fpMode,
  input  logic       fpSummary,
  input  logic       ack,
  output logic       reqValid,
  output srcCode_e   selCode,
  output ctlStrobe_t strobe
);

  logic fpCond;

  always_comb begin
    fpCond = (|fpMode) && fpSummary;
    if (fpCond)                      selCode = SRC_FP;
    else if (extEnable && extPend)   selCode = SRC_EXT;
    else if (extEnable && decPend)   selCode = SRC_DEC;
    else                             selCode = SRC_NONE;
    reqValid       = (selCode != SRC_NONE);
    strobe.takeDec = ack && (selCode == SRC_DEC);
  end

  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!extEnable && !fpCond) |-> !reqValid) else $error("request while disabled"); // R3
  AST_EXT_OVER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (extEnable && extPend && !fpCond) |-> (selCode == SRC_EXT)) else $error("ext lost priority"); // R4
  AST_PENDING_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (extEnable && (extPend || decPend)) |-> reqValid) else $error("pending source dropped"); // R8

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_FP  = 12'h700,
  parameter logic [VEC_W-1:0] VEC_EXT = 12'h500,
  parameter logic [VEC_W-1:0] VEC_DEC = 12'h900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              extLine,
  input  logic              decPulse,
  input  logic              extEnable,
  input  logic [1:0]        fpMode,
  input  logic              fpSummary,
  input  logic              ack,
  output logic              reqValid,
  output logic [1:0]        reqCode,
  output logic [VEC_W-1:0]  reqVector,
  output logic [SAVE_W-1:0] reqSave
);

  logic       extPend;
  logic       decPend;
  srcCode_e   selCode;
  ctlStrobe_t strobe;

  irq_prio_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .extPend(extPend), .decPend(decPend),
    .extEnable(extEnable), .fpMode(fpMode), .fpSummary(fpSummary),
    .ack(ack), .reqValid(reqValid), .selCode(selCode), .strobe(strobe)
  );

  irq_prio_dp #(
    .VEC_W(VEC_W), .VEC_FP(VEC_FP), .VEC_EXT(VEC_EXT), .VEC_DEC(VEC_DEC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .extLine(extLine), .decPulse(decPulse),
    .strobe(strobe), .selCode(selCode),
    .extPend(extPend), .decPend(decPend),
    .vecOut(reqVector), .saveOut(reqSave)
  );

  assign reqCode = selCode;

  AST_FP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fpMode) && fpSummary) |-> (reqVector == VEC_FP && reqSave == 2'b11)) else $error("fp not first"); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> (reqVector == '0 && reqSave == '0)) else $error("idle outputs nonzero"); // R9

endmodule

// File: tb/irq_prio_ctl_test.sv
module irq_prio_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic extLine = 0, decPulse = 0, extEnable = 0, fpSummary = 0, ack = 0;
  logic [1:0] fpMode = 2'b00;
  logic reqValid;
  logic [1:0] reqCode;
  logic [11:0] reqVector;
  logic [1:0] reqSave;

  int total = 0;
  int bad = 0;
  logic mExt = 0, mDec = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctl uut (
    .clk(clk), .rst_n(rst_n), .extLine(extLine), .decPulse(decPulse),
    .extEnable(extEnable), .fpMode(fpMode), .fpSummary(fpSummary), .ack(ack),
    .reqValid(reqValid), .reqCode(reqCode), .reqVector(reqVector), .reqSave(reqSave)
  );

  // expected {valid, code, vector, save}
  function automatic logic [16:0] expect_out(logic ee, logic [1:0] m, logic s, logic pe, logic pd);
    if ((m != 0) && s) return {1'b1, 2'd1, 12'h700, 2'b11};
    if (ee && pe)      return {1'b1, 2'd2, 12'h500, 2'b00};
    if (ee && pd)      return {1'b1, 2'd3, 12'h900, 2'b00};
    return '0;
  endfunction

  function automatic string tag_of(logic [16:0] e);
    case (e[15:14])
      2'd1: return "R2";
      2'd2: return "R4";
      2'd3: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag);
    logic [16:0] exp, act;
    exp = expect_out(extEnable, fpMode, fpSummary, mExt, mDec);
    act = {reqValid, reqCode, reqVector, reqSave};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive after falling edge, check, then advance model at rising edge
  task automatic step(string tag, logic iExt, logic iDec, logic iEe,
                      logic [1:0] iM, logic iS, logic iAck);
    logic [16:0] exp;
    logic nDec;
    @(negedge clk);
    extLine = iExt; decPulse = iDec; extEnable = iEe;
    fpMode = iM; fpSummary = iS; ack = iAck;
    #1;
    exp = expect_out(iEe, iM, iS, mExt, mDec);
    check(tag == "" ? tag_of(exp) : tag);
    nDec = iDec | (mDec & ~(iAck && exp[15:14] == 2'd3));
    @(posedge clk);
    mExt = iExt;
    mDec = nDec;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R1: inputs toggled during reset must not register
    @(negedge clk); extLine = 1; decPulse = 1; #1;
    total++;
    if (reqValid !== 1'b0 || reqCode !== 2'd0 || reqVector !== 12'h0) begin
      bad++; $display("FAIL R1: actual=%b/%h expected=0/0", reqValid, reqVector);
    end
    repeat (2) @(posedge clk);
    @(negedge clk); extLine = 0; decPulse = 0; rst_n = 1;
    step("R1", 0, 0, 0, 2'b00, 0, 0);

    // R2: FP above external, each mode bit, enable irrelevant
    step("R5", 1, 1, 1, 2'b00, 0, 0);
    step("R2", 1, 0, 1, 2'b01, 1, 0);
    step("R2", 1, 0, 0, 2'b10, 1, 1);
    step("R2", 1, 0, 1, 2'b11, 0, 0); // summary low -> ext (R4)
    // R4: ext over dec; R5: ack does not clear ext
    step("R4", 1, 0, 1, 2'b00, 0, 1);
    step("R5", 1, 0, 1, 2'b00, 0, 1);
    step("R5", 0, 0, 1, 2'b00, 0, 0); // flag still set this cycle
    // R6: only dec now, take it
    step("R6", 0, 0, 1, 2'b00, 0, 1);
    step("R6", 0, 0, 1, 2'b00, 0, 0); // consumed
    // R7: pulse while disabled, remembered
    step("R7", 0, 1, 0, 2'b00, 0, 0);
    step("R3", 0, 0, 0, 2'b00, 0, 1); // R8 ack while disabled ignored
    step("R7", 0, 0, 1, 2'b00, 0, 0);
    // R8: ack while FP selected leaves dec pending
    step("R8", 0, 0, 1, 2'b01, 1, 1);
    step("R8", 0, 0, 1, 2'b00, 0, 0);
    // R6: take with simultaneous new pulse keeps it
    step("R6", 0, 1, 1, 2'b00, 0, 1);
    step("R6", 0, 0, 1, 2'b00, 0, 1);
    step("R9", 0, 0, 1, 2'b00, 0, 0);
    step("R9", 0, 0, 0, 2'b10, 0, 1);

    // random phases with different densities
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 400; i++) begin
        int thr;
        thr = (ph == 0) ? 20 : (ph == 1) ? 50 : 80;
        step("", ($urandom % 100) < thr, ($urandom % 100) < thr / 2,
             ($urandom % 100) < 60, (($urandom % 100) < thr / 3) ? 2'($urandom) : 2'b00,
             ($urandom % 100) < thr, ($urandom % 100) < 50);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule